// File: doc/BRIEF.md
# Bus-Master DMA Channel Register Set

This block holds the host-visible control state of one bus-master DMA channel of a disk controller: a command byte, a status byte and a 32-bit base address for the physical region descriptor table. The host reaches all three through one 8-byte register window. Each access names a byte offset and a width of 1, 2 or 4 bytes. Writes are merged per byte lane. Reads return the addressed lanes right-aligned.

The block does not walk descriptors and does not talk to the drive. It turns changes of the start bit into one-cycle start and cancel pulses for an external DMA engine. On a start it reloads a current table pointer from the base register. It keeps the active status bit under the control of the engine and the start bit only. It records drive interrupts in the status byte and passes the drive interrupt level on to the host.

Top module: `bm_channel_regs`

## Requirements
- R1: The command byte sits at window offset 0. Only bit 0 (start) and bit 3 (direction, driven on `dma_dir`) are kept, and every other command bit reads as 0.
- R2: A command write whose start bit equals the stored start bit produces no start or cancel pulse and leaves the active bit unchanged.
- R3: A command write that changes the start bit from 1 to 0 raises `dma_cancel` for one cycle after the write edge and clears the active bit (status bit 0) at that edge.
- R4: A command write that changes the start bit from 0 to 1 loads `table_ptr` from the base register. If the channel is inactive, the same write sets the active bit and raises `dma_start` for one cycle.
- R5: The status byte sits at window offset 2. Status bits 5 and 6 take the written value. A host write never changes the active bit, and an `eng_stop` pulse clears it.
- R6: Status bit 1 (error) is set by an `eng_err` pulse. Status bit 2 (interrupt) is set as in R7. Writing 1 to either bit clears it and writing 0 leaves it unchanged. When a set and a clear arrive in the same cycle, the set wins.
- R7: A 0-to-1 change of `drv_irq` sets the interrupt status bit. `host_irq` always equals `drv_irq`, and a 1-to-0 change of `drv_irq` does not alter the status byte.
- R8: The base register occupies window offsets 4 to 7, least significant byte first. A write updates only the lanes it covers, and bits 1:0 of the base always read as 0.
- R9: `host_size` encodes the access width as 0 for 1 byte, 1 for 2 bytes, and 2 or 3 for 4 bytes. A read returns the covered lanes starting at `host_off` in ascending byte order, and lanes past the window or outside the access read 0. Offsets 1 and 3 always read 0.
- R10: After reset the command, status, base and pointer are all 0, and no pulse is asserted.
- R11: `table_ptr` changes only on the start transition of R4. Writes to the base register alone leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_we | input | 1 | Host write strobe for the addressed lanes |
| host_off | input | 3 | Byte offset in the register window |
| host_size | input | 2 | Access width code (R9) |
| host_wdata | input | 32 | Write data, right-aligned |
| host_rdata | output | 32 | Read data for the current offset and width |
| eng_stop | input | 1 | Engine pulse: transfer finished, clear active |
| eng_err | input | 1 | Engine pulse: set the error status bit |
| drv_irq | input | 1 | Drive interrupt level |
| host_irq | output | 1 | Interrupt level to the host |
| dma_start | output | 1 | One-cycle start request to the engine |
| dma_cancel | output | 1 | One-cycle cancel request to the engine |
| dma_dir | output | 1 | Stored direction bit |
| table_base | output | 32 | Descriptor table base register |
| table_ptr | output | 32 | Current table pointer, reloaded on start |

## Verification
The assertions assume that the engine never asserts `eng_stop` in the same cycle as a start transition. They also assume that `drv_irq` is a clean synchronous level, so a rise seen at one edge is a rise the block itself records. The stimulus meets both assumptions. It drives every input at the falling edge and pulses `eng_stop` only in cycles without a host write. The one overlap of a set and a clear on the error bit is produced on purpose, because R6 defines its outcome.

// File: rtl/bmreg_pkg.sv
// Package: shared layout constants and access-width encoding for the
// bus-master channel register set. Assumes a little-endian 8-byte window.
package bmreg_pkg;
    localparam int HOST_BYTES = 4;
    localparam int WIN_BYTES  = 8;
    localparam int OFF_W      = $clog2(WIN_BYTES);
    localparam int CMD_LANE   = 0;
    localparam int STAT_LANE  = 2;
    localparam int BASE_LANE  = 4;
    localparam int CMD_GO     = 0;
    localparam int CMD_DIR    = 3;
    localparam int ST_ACT     = 0;
    localparam int ST_ERR     = 1;
    localparam int ST_INT     = 2;
    localparam int ST_HOST_LO = 5;
    localparam int ST_HOST_HI = 6;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_WALT = 2'd3
    } acc_size_e;
endpackage

// File: rtl/bmreg_lanes.sv
// Module: byte-lane decoder for the register window. Turns an offset and
// width into per-lane write enables and shifted write data, and extracts
// right-aligned read data. Assumes bytes past the window are dropped.
module bmreg_lanes
    import bmreg_pkg::*;
#(
    parameter int HB = HOST_BYTES,
    parameter int WB = WIN_BYTES,
    parameter int OW = OFF_W
) (
    input  logic              wr,
    input  logic [OW-1:0]     off,
    input  logic [1:0]        size,
    input  logic [8*HB-1:0]   wdata,
    input  logic [8*WB-1:0]   win_rd,
    output logic [WB-1:0]     lane_we,
    output logic [8*WB-1:0]   lane_wd,
    output logic [8*HB-1:0]   rdata
);
    localparam int PAD = WB - HB;

    logic [HB-1:0]   size_mask;
    logic [WB-1:0]   lane_sel;
    logic [8*WB-1:0] rd_wide;
    logic [8*HB-1:0] byte_mask;

    // Width code to a mask of covered host bytes.
    always_comb begin
        case (acc_size_e'(size))
            SZ_BYTE: size_mask = HB'(1);
            SZ_HALF: size_mask = HB'(3);
            default: size_mask = '1;
        endcase
    end

    // Shift mask and data to the addressed lanes, and align read data.
    always_comb begin
        lane_sel = {{PAD{1'b0}}, size_mask} << off;
        lane_we  = wr ? lane_sel : '0;
        lane_wd  = {{(8*PAD){1'b0}}, wdata} << {off, 3'b000};
        rd_wide  = win_rd >> {off, 3'b000};
        for (int i = 0; i < HB; i++) begin
            byte_mask[8*i +: 8] = {8{size_mask[i]}};
        end
        rdata = rd_wide[8*HB-1:0] & byte_mask;
    end
endmodule

// File: rtl/bmreg_cmd.sv
// Module: command byte. Keeps the start and direction bits and detects
// start-bit changes. Assumes at most one command write per cycle.
module bmreg_cmd
    import bmreg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       we,
    input  logic [7:0] wd,
    input  logic       active,
    output logic       start_req,
    output logic       cancel_req,
    output logic       start_pls,
    output logic       cancel_pls,
    output logic [7:0] cmd_byte
);
    logic go_q;
    logic dir_q;

    // Start-bit edges requested by the current write.
    always_comb begin
        start_req  = we &&  wd[CMD_GO] && !go_q;
        cancel_req = we && !wd[CMD_GO] &&  go_q;
    end

    // Store kept bits and register the engine pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            go_q       <= 1'b0;
            dir_q      <= 1'b0;
            start_pls  <= 1'b0;
            cancel_pls <= 1'b0;
        end else begin
            start_pls  <= start_req && !active;
            cancel_pls <= cancel_req;
            if (we) begin
                go_q  <= wd[CMD_GO];
                dir_q <= wd[CMD_DIR];
            end
        end
    end

    // Present the byte with unused bits at zero.
    always_comb begin
        cmd_byte          = 8'h00;
        cmd_byte[CMD_GO]  = go_q;
        cmd_byte[CMD_DIR] = dir_q;
    end

    assert_same_go_no_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (we && (wd[CMD_GO] == go_q)) |=> (!start_pls && !cancel_pls));
endmodule

// File: rtl/bmreg_status.sv
// Module: status byte. Owns the active bit, the sticky error and interrupt
// bits and two host bits. Assumes drv_irq is synchronous to clk.
module bmreg_status
    import bmreg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       we,
    input  logic [7:0] wd,
    input  logic       set_act,
    input  logic       clr_act,
    input  logic       eng_err,
    input  logic       drv_irq,
    output logic [7:0] stat_byte,
    output logic       host_irq
);
    logic       act_q;
    logic       err_q;
    logic       int_q;
    logic       irq_prev;
    logic [1:0] host_bits;

    // Update each status field under its own set/clear rule.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q     <= 1'b0;
            err_q     <= 1'b0;
            int_q     <= 1'b0;
            irq_prev  <= 1'b0;
            host_bits <= 2'b00;
        end else begin
            irq_prev <= drv_irq;
            if (set_act)       act_q <= 1'b1;
            else if (clr_act)  act_q <= 1'b0;
            if (we)            host_bits <= wd[ST_HOST_HI:ST_HOST_LO];
            if (eng_err)                err_q <= 1'b1;
            else if (we && wd[ST_ERR])  err_q <= 1'b0;
            if (drv_irq && !irq_prev)   int_q <= 1'b1;
            else if (we && wd[ST_INT])  int_q <= 1'b0;
        end
    end

    // Assemble the readable byte and pass the interrupt level through.
    always_comb begin
        stat_byte                        = 8'h00;
        stat_byte[ST_ACT]                = act_q;
        stat_byte[ST_ERR]                = err_q;
        stat_byte[ST_INT]                = int_q;
        stat_byte[ST_HOST_HI:ST_HOST_LO] = host_bits;
        host_irq                         = drv_irq;
    end

    assert_host_keeps_active_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (we && !set_act && !clr_act) |=> (act_q == $past(act_q)));
    assert_err_clear_by_one_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(err_q) |-> $past(we && wd[ST_ERR]));
    assert_irq_rise_sets_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(drv_irq) |=> int_q);
endmodule

// File: rtl/bmreg_base.sv
// Module: descriptor table base with byte-lane merge, and the current
// table pointer reloaded from it on a start. Assumes PW is a byte multiple.
module bmreg_base #(
    parameter int PW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [PW/8-1:0] lane_we,
    input  logic [PW-1:0] wd,
    input  logic          reload,
    output logic [PW-1:0] base_q,
    output logic [PW-1:0] ptr_q
);
    localparam int NB = PW / 8;

    logic [PW-1:0] base_nx;

    // Merge written lanes and force dword alignment.
    always_comb begin
        base_nx = base_q;
        for (int i = 0; i < NB; i++) begin
            if (lane_we[i]) base_nx[8*i +: 8] = wd[8*i +: 8];
        end
        base_nx[1:0] = 2'b00;
    end

    // Hold base and pointer, reloading the pointer on start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            ptr_q  <= '0;
        end else begin
            base_q <= base_nx;
            if (reload) ptr_q <= base_q;
        end
    end

    assert_low_lane_merge_R8: assert property (@(posedge clk) disable iff (!rst_n)
        lane_we[0] |=> (base_q[7:2] == $past(wd[7:2])));
    assert_ptr_holds_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !reload |=> $stable(ptr_q));
endmodule

// File: rtl/bm_channel_regs.sv
// Module: top of one bus-master channel register set. Decodes host lanes
// and wires command, status and base blocks. Assumes an external engine
// reacts to dma_start / dma_cancel and reports eng_stop / eng_err.
module bm_channel_regs
    import bmreg_pkg::*;
#(
    parameter int PTR_BYTES = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    host_we,
    input  logic [OFF_W-1:0]        host_off,
    input  logic [1:0]              host_size,
    input  logic [8*HOST_BYTES-1:0] host_wdata,
    output logic [8*HOST_BYTES-1:0] host_rdata,
    input  logic                    eng_stop,
    input  logic                    eng_err,
    input  logic                    drv_irq,
    output logic                    host_irq,
    output logic                    dma_start,
    output logic                    dma_cancel,
    output logic                    dma_dir,
    output logic [8*PTR_BYTES-1:0]  table_base,
    output logic [8*PTR_BYTES-1:0]  table_ptr
);
    localparam int PW = 8 * PTR_BYTES;

    logic [WIN_BYTES-1:0]   lane_we;
    logic [8*WIN_BYTES-1:0] lane_wd;
    logic [8*WIN_BYTES-1:0] win_rd;
    logic [7:0]             cmd_byte;
    logic [7:0]             stat_byte;
    logic                   start_req;
    logic                   cancel_req;

    bmreg_lanes u_lanes (
        .wr      (host_we),
        .off     (host_off),
        .size    (host_size),
        .wdata   (host_wdata),
        .win_rd  (win_rd),
        .lane_we (lane_we),
        .lane_wd (lane_wd),
        .rdata   (host_rdata)
    );

    bmreg_cmd u_cmd (
        .clk        (clk),
        .rst_n      (rst_n),
        .we         (lane_we[CMD_LANE]),
        .wd         (lane_wd[8*CMD_LANE +: 8]),
        .active     (stat_byte[ST_ACT]),
        .start_req  (start_req),
        .cancel_req (cancel_req),
        .start_pls  (dma_start),
        .cancel_pls (dma_cancel),
        .cmd_byte   (cmd_byte)
    );

    bmreg_status u_status (
        .clk       (clk),
        .rst_n     (rst_n),
        .we        (lane_we[STAT_LANE]),
        .wd        (lane_wd[8*STAT_LANE +: 8]),
        .set_act   (start_req),
        .clr_act   (cancel_req || eng_stop),
        .eng_err   (eng_err),
        .drv_irq   (drv_irq),
        .stat_byte (stat_byte),
        .host_irq  (host_irq)
    );

    bmreg_base #(.PW(PW)) u_base (
        .clk     (clk),
        .rst_n   (rst_n),
        .lane_we (lane_we[BASE_LANE +: PTR_BYTES]),
        .wd      (lane_wd[8*BASE_LANE +: PW]),
        .reload  (start_req),
        .base_q  (table_base),
        .ptr_q   (table_ptr)
    );

    // Build the readable window image; unused lanes read zero.
    always_comb begin
        win_rd = '0;
        win_rd[8*CMD_LANE  +: 8]  = cmd_byte;
        win_rd[8*STAT_LANE +: 8]  = stat_byte;
        win_rd[8*BASE_LANE +: PW] = table_base;
        dma_dir = cmd_byte[CMD_DIR];
    end

    assert_cancel_clears_active_R3: assert property (@(posedge clk) disable iff (!rst_n)
        dma_cancel |-> !stat_byte[ST_ACT]);
    assert_start_loads_ptr_R4: assert property (@(posedge clk) disable iff (!rst_n)
        dma_start |-> (stat_byte[ST_ACT] && (table_ptr == table_base)));
    assert_pulses_exclusive_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !(dma_start && dma_cancel));
endmodule

// File: tb/bm_channel_regs_test.sv
module bm_channel_regs_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_we = 1'b0;
    logic [2:0]  host_off = '0;
    logic [1:0]  host_size = '0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;
    logic        eng_stop = 1'b0;
    logic        eng_err = 1'b0;
    logic        drv_irq = 1'b0;
    logic        host_irq, dma_start, dma_cancel, dma_dir;
    logic [31:0] table_base, table_ptr;

    int checks = 0;
    int errs = 0;

    always #4 clk = ~clk;

    bm_channel_regs uut (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] o, input logic [1:0] s, input logic [31:0] d);
        @(negedge clk);
        host_we = 1'b1; host_off = o; host_size = s; host_wdata = d;
        @(posedge clk); #1;
        host_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] o, input logic [1:0] s, output logic [31:0] q);
        @(negedge clk);
        host_off = o; host_size = s;
        #1 q = host_rdata;
    endtask

    task automatic pulse_stop();
        @(negedge clk); eng_stop = 1'b1;
        @(posedge clk); #1 eng_stop = 1'b0;
    endtask

    task automatic pulse_err();
        @(negedge clk); eng_err = 1'b1;
        @(posedge clk); #1 eng_err = 1'b0;
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; errs++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        logic [31:0] q, mb, pat, expw;
        logic ms, mact, merr, mint;
        logic [7:0] est;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R10: reset state
        rd(3'd0, 2'd2, q); chk("R10 cmd/status", q, 32'h0);
        rd(3'd4, 2'd2, q); chk("R10 base", q, 32'h0);
        chk("R10 ptr", table_ptr, 32'h0);
        chk("R10 pulses", {dma_start, dma_cancel, dma_dir}, 32'h0);

        // R8: establish a base for the command sweep
        wr(3'd4, 2'd2, 32'h1234_567B);
        chk("R8 low bits forced", table_base, 32'h1234_5678);

        // R1 R2 R3 R4: sweep every command byte value
        ms = 1'b0; mact = 1'b0;
        for (int v = 0; v < 256; v++) begin
            logic es, ec;
            if (v % 7 == 3) begin pulse_stop(); mact = 1'b0; end
            es = 1'b0; ec = 1'b0;
            if (v[0] != ms) begin
                if (!v[0]) begin ec = 1'b1; mact = 1'b0; end
                else begin es = !mact; mact = 1'b1; end
            end
            ms = v[0];
            wr(3'd0, 2'd0, 32'(v));
            chk("R2 R4 start pulse", dma_start, es);
            chk("R2 R3 cancel pulse", dma_cancel, ec);
            if (es) chk("R4 ptr reload", table_ptr, 32'h1234_5678);
            rd(3'd0, 2'd0, q); chk("R1 cmd readback", q, 32'(v & 9));
            chk("R1 dir", dma_dir, v[3]);
            rd(3'd2, 2'd0, q); chk("R3 R4 active", q & 32'h1, 32'(mact));
        end

        // R5 R6 R7: sweep status writes, inactive then active
        wr(3'd0, 2'd0, 32'h0);
        for (int a = 0; a < 2; a++) begin
            if (a == 1) wr(3'd0, 2'd0, 32'h1);
            mact = a[0];
            rd(3'd2, 2'd0, q);
            merr = q[1]; mint = q[2];
            for (int v = 0; v < 256; v++) begin
                if (v[3]) begin pulse_err(); merr = 1'b1; end
                if (v[4]) begin
                    @(negedge clk) drv_irq = 1'b1;
                    @(posedge clk); #1;
                    chk("R7 host_irq high", host_irq, 1'b1);
                    mint = 1'b1;
                    @(negedge clk) drv_irq = 1'b0;
                    #1 chk("R7 host_irq low", host_irq, 1'b0);
                end
                wr(3'd2, 2'd0, 32'(v));
                merr = merr & ~v[1];
                mint = mint & ~v[2];
                est = {1'b0, v[6:5], 2'b00, mint, merr, mact};
                rd(3'd2, 2'd0, q); chk("R5 R6 status", q, 32'(est));
            end
        end

        // R6: set wins over a same-cycle clear
        @(negedge clk);
        host_we = 1'b1; host_off = 3'd2; host_size = 2'd0; host_wdata = 32'h2; eng_err = 1'b1;
        @(posedge clk); #1 host_we = 1'b0; eng_err = 1'b0;
        rd(3'd2, 2'd0, q); chk("R6 set wins", q & 32'h2, 32'h2);

        // R7: falling drive level leaves a cleared interrupt bit at 0
        @(negedge clk) drv_irq = 1'b1;
        @(posedge clk); #1;
        wr(3'd2, 2'd0, 32'h4);
        rd(3'd2, 2'd0, q); chk("R7 cleared while high", q & 32'h4, 32'h0);
        @(negedge clk) drv_irq = 1'b0;
        @(posedge clk); #1;
        rd(3'd2, 2'd0, q); chk("R7 fall no effect", q & 32'h4, 32'h0);

        // R8 R9 R11: every offset and width over the base lanes
        mb = table_base;
        expw = table_ptr;
        for (int o = 4; o < 8; o++) begin
            for (int s = 0; s < 3; s++) begin
                int n;
                logic [31:0] msk;
                n = (s == 0) ? 1 : (s == 1) ? 2 : 4;
                pat = 32'h9E37_79B9 * 32'(o * 3 + s + 1);
                for (int k = 0; k < n; k++) begin
                    if (o + k < 8) mb[8*(o+k-4) +: 8] = pat[8*k +: 8];
                end
                mb[1:0] = 2'b00;
                wr(3'(o), 2'(s), pat);
                chk("R8 base merge", table_base, mb);
                chk("R11 ptr held", table_ptr, expw);
                rd(3'd4, 2'd2, q); chk("R9 full base read", q, mb);
                msk = (n == 4) ? 32'hFFFF_FFFF : ((32'h1 << (8 * n)) - 1);
                rd(3'(o), 2'(s), q);
                chk("R9 lane read", q, (mb >> (8 * (o - 4))) & msk);
            end
        end

        // R9: size code 3 and the empty lanes 1 and 3
        rd(3'd4, 2'd3, q); chk("R9 size code 3", q, mb);
        rd(3'd0, 2'd2, q);
        chk("R9 empty lanes", q & 32'hFF00_FF00, 32'h0);

        // R4 R11: restart reloads the new base into the pointer
        wr(3'd0, 2'd0, 32'h0);
        wr(3'd0, 2'd0, 32'h1);
        chk("R4 start pulse", dma_start, 1'b1);
        chk("R11 ptr reloaded", table_ptr, mb);

        finish_run();
    end
endmodule